// File: doc/BRIEF.md
# Universal Shift Register with Enable

A register of parameterised width. On each rising clock edge a two-bit mode code picks its next value. The four choices are keep the value, shift toward the least-significant end, shift toward the most-significant end, or copy a parallel word. Each shift direction has its own serial input for the bit that enters the vacated end. The bit that leaves the other end is dropped inside the register.

An enable input gates the mode code before it reaches the per-bit selectors. With the enable low, every selector sees the keep code, whatever the mode code says. The clock is never gated. Both end bits are brought out on serial-output pins, so several instances can be chained into one wider register. The width must be at least 2. The register clears asynchronously on an active-low reset.

Top module: `univ_shift_reg`

## Requirements
- R1: While `rst_ni` is low, `q_o` is all zeros, and it goes to zero without waiting for a clock edge.
- R2: With `en_i` high and `mode_i` = 2'b00, `q_o` keeps its value across the clock edge.
- R3: With `en_i` high and `mode_i` = 2'b01 (shift right), each bit i < W-1 takes the old bit i+1, and bit W-1 takes `ser_r_i`. The old bit 0 is discarded.
- R4: With `en_i` high and `mode_i` = 2'b10 (shift left), each bit i > 0 takes the old bit i-1, and bit 0 takes `ser_l_i`. The old bit W-1 is discarded.
- R5: With `en_i` high and `mode_i` = 2'b11, `q_o` takes the value of `par_i` on the edge.
- R6: With `en_i` low, `q_o` keeps its value for every value of `mode_i`, `ser_r_i`, `ser_l_i` and `par_i`.
- R7: `ser_msb_o` always equals `q_o[W-1]`, and `ser_lsb_o` always equals `q_o[0]`.
- R8: Two instances behave as a single 2W-bit register in all four modes when wired as follows. The low instance's `ser_msb_o` drives the high instance's `ser_l_i`. The high instance's `ser_lsb_o` drives the low instance's `ser_r_i`. The parallel word is split across the two, and both share `en_i` and `mode_i`.
- R9: Starting from 4'b1101, a right shift with serial input 0 gives 4'b0110. A left shift with serial input 1 then gives 4'b1101, and a hold leaves 4'b1101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the register |
| en_i | input | 1 | Enable; when low the mode code is forced to hold |
| mode_i | input | 2 | Mode: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_r_i | input | 1 | Bit entering the MSB on a right shift |
| ser_l_i | input | 1 | Bit entering the LSB on a left shift |
| par_i | input | W | Parallel load word |
| q_o | output | W | Register contents |
| ser_msb_o | output | 1 | Current MSB, for chaining left shifts |
| ser_lsb_o | output | 1 | Current LSB, for chaining right shifts |

## Verification
The only state is the register itself, and every bit of it drives `q_o` with no delay. A wrong mux leg or a wrong end-bit connection therefore shows on `q_o` one edge after the mode that uses it. The bench compares `q_o` after every edge. The serial outputs carry the end bits of that same state. A broken cascade wire shows in the 16-bit chained comparison on the first shift that crosses the boundary between the two instances. An enable gate that leaks a raw code shows as a change in `q_o` on the first disabled edge that carries a non-hold mode.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_mode_gate.sv
module usr_mode_gate
  import usr_pkg::*;
(
  input  logic       en_i,
  input  logic [1:0] mode_i,
  output mode_e      mode_o
);
  // Each select line ANDed with enable: low enable collapses to hold.
  assign mode_o = mode_e'(mode_i & {2{en_i}});
endmodule

// File: rtl/usr_bit_sel.sv
module usr_bit_sel
  import usr_pkg::*;
(
  input  mode_e mode_i,
  input  logic  cur_i,
  input  logic  from_hi_i,
  input  logic  from_lo_i,
  input  logic  par_i,
  output logic  nxt_o
);
  always_comb begin
    unique case (mode_i)
      MODE_HOLD: nxt_o = cur_i;
      MODE_SHR:  nxt_o = from_hi_i;
      MODE_SHL:  nxt_o = from_lo_i;
      MODE_LOAD: nxt_o = par_i;
      default:   nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/usr_shift_core.sv
module usr_shift_core
  import usr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mode_e        mode_i,
  input  logic         ser_r_i,
  input  logic         ser_l_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hi_nb;
    logic lo_nb;
    if (i == MSB) begin : g_top
      assign hi_nb = ser_r_i;
    end else begin : g_mid_hi
      assign hi_nb = q_q[i+1];
    end
    if (i == 0) begin : g_bot
      assign lo_nb = ser_l_i;
    end else begin : g_mid_lo
      assign lo_nb = q_q[i-1];
    end

    usr_bit_sel u_sel (
      .mode_i    (mode_i),
      .cur_i     (q_q[i]),
      .from_hi_i (hi_nb),
      .from_lo_i (lo_nb),
      .par_i     (par_i[i]),
      .nxt_o     (q_d[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  AST_SHR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_SHR |=> q_q == {$past(ser_r_i), $past(q_q[MSB:1])}); // R3
  AST_SHL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_SHL |=> q_q == {$past(q_q[MSB-1:0]), $past(ser_l_i)}); // R4
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [1:0]   mode_i,
  input  logic         ser_r_i,
  input  logic         ser_l_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] q_o,
  output logic         ser_msb_o,
  output logic         ser_lsb_o
);
  mode_e eff_mode;

  usr_mode_gate u_gate (
    .en_i   (en_i),
    .mode_i (mode_i),
    .mode_o (eff_mode)
  );

  usr_shift_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (eff_mode),
    .ser_r_i (ser_r_i),
    .ser_l_i (ser_l_i),
    .par_i   (par_i),
    .q_o     (q_o)
  );

  // Cascade taps: the bits a shift would drop.
  assign ser_msb_o = q_o[W-1];
  assign ser_lsb_o = q_o[0];

  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o)); // R6
  AST_HOLD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == 2'b00 |=> $stable(q_o)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == 2'b11 |=> q_o == $past(par_i)); // R5
  AST_SHR_PORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == 2'b01 |=> ser_lsb_o == $past(q_o[1])); // R3
endmodule

// File: tb/univ_shift_reg_test.sv
module univ_shift_reg_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sr = 1'b0;
  logic        sl = 1'b0;
  logic [15:0] par = 16'h0;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m4 = '0, m8 = '0, m16 = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  logic [3:0]  q4;
  logic [7:0]  q8, qlo, qhi;
  logic        m4_msb, m4_lsb, m8_msb, m8_lsb;
  logic        lo_msb, lo_lsb, hi_msb, hi_lsb;

  univ_shift_reg #(.W(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode),
    .ser_r_i(sr), .ser_l_i(sl), .par_i(par[3:0]),
    .q_o(q4), .ser_msb_o(m4_msb), .ser_lsb_o(m4_lsb));

  univ_shift_reg #(.W(8)) u8 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode),
    .ser_r_i(sr), .ser_l_i(sl), .par_i(par[7:0]),
    .q_o(q8), .ser_msb_o(m8_msb), .ser_lsb_o(m8_lsb));

  univ_shift_reg #(.W(8)) u_lo (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode),
    .ser_r_i(hi_lsb), .ser_l_i(sl), .par_i(par[7:0]),
    .q_o(qlo), .ser_msb_o(lo_msb), .ser_lsb_o(lo_lsb));

  univ_shift_reg #(.W(8)) u_hi (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode),
    .ser_r_i(sr), .ser_l_i(lo_msb), .par_i(par[15:8]),
    .q_o(qhi), .ser_msb_o(hi_msb), .ser_lsb_o(hi_lsb));

  function automatic logic [15:0] ref_next(input logic [15:0] c, input int w,
      input logic e, input logic [1:0] m, input logic r, input logic l,
      input logic [15:0] p);
    logic [16:0] mask;
    mask = (17'd1 << w) - 17'd1;
    if (!e) return c;
    case (m)
      2'b01:   return (c >> 1) | (16'(r) << (w - 1));
      2'b10:   return ((c << 1) | 16'(l)) & mask[15:0];
      2'b11:   return p & mask[15:0];
      default: return c;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, {12'h0, q4}, m4);
    check(req, {8'h0, q8}, m8);
    check("R8", {qhi, qlo}, m16);
    check("R7", {14'h0, m4_msb, m4_lsb}, {14'h0, m4[3], m4[0]});
    check("R7", {14'h0, m8_msb, m8_lsb}, {14'h0, m8[7], m8[0]});
    check("R8", {14'h0, hi_msb, lo_lsb}, {14'h0, m16[15], m16[0]});
  endtask

  task automatic step(input string req, input logic e, input logic [1:0] m,
      input logic r, input logic l, input logic [15:0] p);
    @(negedge clk);
    en = e; mode = m; sr = r; sl = l; par = p;
    m4  = ref_next(m4, 4, e, m, r, l, p);
    m8  = ref_next(m8, 8, e, m, r, l, p);
    m16 = ref_next(m16, 16, e, m, r, l, p);
    @(posedge clk);
    #1;
    check_all(req);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    m4 = '0; m8 = '0; m16 = '0;
    check_all("R1");
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_example; // R9
    step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 16'hA5BD);
    check("R9", {12'h0, q4}, 16'h000D);
    step("R3", 1'b1, 2'b01, 1'b0, 1'b0, 16'h0000);
    check("R9", {12'h0, q4}, 16'h0006);
    step("R4", 1'b1, 2'b10, 1'b0, 1'b1, 16'h0000);
    check("R9", {12'h0, q4}, 16'h000D);
    step("R2", 1'b1, 2'b00, 1'b1, 1'b0, 16'hFFFF);
    check("R9", {12'h0, q4}, 16'h000D);
  endtask

  task automatic t_enable_off;
    step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 16'h3C96);
    for (int m = 0; m < 4; m++) begin
      step("R6", 1'b0, 2'(m), 1'b1, 1'b1, 16'hFFFF);
      step("R6", 1'b0, 2'(m), 1'b0, 1'b0, 16'h0000);
    end
  endtask

  task automatic t_walk;
    step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 16'h8001);
    for (int i = 0; i < 18; i++) step("R3", 1'b1, 2'b01, i[0], 1'b0, 16'h0);
    step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 16'h0180);
    for (int i = 0; i < 18; i++) step("R4", 1'b1, 2'b10, 1'b0, ~i[1], 16'h0);
  endtask

  task automatic t_mixed;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R2", lfsr[0] | lfsr[5], lfsr[2:1], lfsr[3], lfsr[4],
           {lfsr[7:0], lfsr[15:8]});
    end
  endtask

  task automatic t_async_reset;
    step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 16'hFFFF);
    @(negedge clk);
    #1;
    rst_ni = 1'b0;
    #1;
    m4 = '0; m8 = '0; m16 = '0;
    check_all("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 16'h1234);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_example();
        t_enable_off();
        t_walk();
        t_mixed();
        t_async_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule